// File: doc/BRIEF.md
# Descending Stack Pointer Unit

This unit owns the 16-bit stack pointer of a small 8-bit processor core whose data memory is one byte wide. The stack grows toward lower addresses. Each request from the core is turned into a sequence of byte accesses: the unit drives the memory address, the write strobe, the read strobe and the write byte, and it moves the pointer. Data pushes and pops move one byte. Return-address pushes, used on calls and interrupt entry, and return-address pops, used on returns, move two bytes over two consecutive cycles.

Software sees the pointer as two 8-bit registers, a low half and a high half, and can write either or both. A parameter can remove the high half for parts with a small data space; the upper byte then stays at the upper byte of the reset value. The reset value is the top of RAM and is a parameter. Software is expected to keep the pointer above 0x0100. A sticky error flag reports any push that writes below that floor.

Top module: `stkptr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer loads `RAM_END` (default 0x08FF), and `stack_err`, `busy`, `pop_valid` and `ret_valid` clear.
- R2: A byte push (`op_kind` = 0) writes `push_data` to the address equal to the current pointer in the cycle it is accepted. The pointer is then one lower.
- R3: A byte pop (`op_kind` = 1) reads the address one above the pointer in the cycle it is accepted. The pointer is then one higher. In the next cycle `pop_valid` is high for one cycle with the byte in `pop_data`.
- R4: A return-address push (`op_kind` = 2) writes bits 7:0 of `ret_addr_in` at the current pointer in the accept cycle. It writes bits 15:8 one address lower in the following cycle, while `busy` is high. The pointer ends two lower.
- R5: A return-address pop (`op_kind` = 3) reads the high byte from pointer+1 in the accept cycle and the low byte from the next higher address in the following cycle, while `busy` is high. In the cycle after that, `ret_valid` pulses with the 16-bit address on `ret_addr_out`. The pointer ends two higher.
- R6: A request is accepted only when `op_valid` is high and `busy` is low. A request presented while `busy` is high is ignored: no memory access and no pointer change.
- R7: `reg_we_lo` loads `reg_wdata` into pointer bits 7:0, and `reg_we_hi` loads it into bits 15:8, effective the next cycle. Both may be used together. `sp_lo` and `sp_hi` always show the pointer halves.
- R8: A register write in a cycle where a request is accepted, or while `busy` is high, is ignored. The pointer follows the stack operation only.
- R9: Any stack write to an address below 0x0100 sets `stack_err` from the next cycle. The write still happens. The flag stays set until reset or an applied register write clears it.
- R10: The memory write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Stack request present |
| op_kind | input | 2 | 0 byte push, 1 byte pop, 2 return-address push, 3 return-address pop |
| push_data | input | 8 | Byte to push |
| ret_addr_in | input | 16 | Return address to push |
| reg_we_lo | input | 1 | Write pointer low half |
| reg_we_hi | input | 1 | Write pointer high half |
| reg_wdata | input | 8 | Register write byte |
| mem_rdata | input | 8 | Read byte from data memory (same-cycle) |
| mem_addr | output | 16 | Data memory address |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| mem_wdata | output | 8 | Data memory write byte |
| busy | output | 1 | Second byte of a two-byte operation in progress |
| pop_data | output | 8 | Popped byte |
| pop_valid | output | 1 | One-cycle pulse: `pop_data` valid |
| ret_addr_out | output | 16 | Popped return address |
| ret_valid | output | 1 | One-cycle pulse: `ret_addr_out` valid |
| sp_lo | output | 8 | Pointer bits 7:0 |
| sp_hi | output | 8 | Pointer bits 15:8 |
| stack_err | output | 1 | Sticky flag: a push wrote below 0x0100 |

## Verification
The hardest case to reach is the second cycle of a two-byte operation while the core keeps requesting and software writes a pointer register. In that cycle the request and the register write must both be dropped, while the high byte still lands one address lower. The stimulus holds `op_valid` with a different push request and raises `reg_we_lo` exactly in the `busy` cycle. It then checks the final pointer and the memory byte the stray push would have written. A return-address push that starts at 0x0100 exercises the floor check across the byte boundary of one operation.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int SP_W   = 16;
    localparam int BYTE_W = 8;

    typedef logic [SP_W-1:0]   sp_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        OP_PUSH_B  = 2'd0,
        OP_POP_B   = 2'd1,
        OP_PUSH_RA = 2'd2,
        OP_POP_RA  = 2'd3
    } stk_op_e;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PUSH_HI = 2'd1,
        SEQ_POP_LO  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_INC  = 2'd2
    } sp_step_e;

    typedef struct packed {
        logic  we;
        logic  re;
        sp_t   addr;
        byte_t wdata;
    } mem_req_t;

    function automatic sp_t apply_step(sp_t cur, sp_step_e s);
        case (s)
            STEP_DEC: return cur - sp_t'(1);
            STEP_INC: return cur + sp_t'(1);
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/stkptr_seq.sv
module stkptr_seq
    import stkptr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_valid,
    input  stk_op_e  op_kind,
    input  byte_t    push_data,
    input  sp_t      ret_addr_in,
    input  sp_t      sp,
    input  byte_t    mem_rdata,
    output mem_req_t req,
    output sp_step_e step,
    output logic     busy,
    output byte_t    pop_data,
    output logic     pop_valid,
    output sp_t      ret_addr_out,
    output logic     ret_valid
);

    seq_state_e state_q, state_d;
    byte_t      hold_q;
    logic       accept;

    assign busy   = (state_q != SEQ_IDLE);
    assign accept = (state_q == SEQ_IDLE) && op_valid;

    always_comb begin
        req     = '0;
        step    = STEP_HOLD;
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: begin
                if (op_valid) begin
                    case (op_kind)
                        OP_PUSH_B: begin
                            req.we    = 1'b1;
                            req.addr  = sp;
                            req.wdata = push_data;
                            step      = STEP_DEC;
                        end
                        OP_POP_B: begin
                            req.re   = 1'b1;
                            req.addr = sp + sp_t'(1);
                            step     = STEP_INC;
                        end
                        OP_PUSH_RA: begin
                            req.we    = 1'b1;
                            req.addr  = sp;
                            req.wdata = ret_addr_in[BYTE_W-1:0];
                            step      = STEP_DEC;
                            state_d   = SEQ_PUSH_HI;
                        end
                        default: begin
                            req.re   = 1'b1;
                            req.addr = sp + sp_t'(1);
                            step     = STEP_INC;
                            state_d  = SEQ_POP_LO;
                        end
                    endcase
                end
            end
            SEQ_PUSH_HI: begin
                req.we    = 1'b1;
                req.addr  = sp;
                req.wdata = hold_q;
                step      = STEP_DEC;
                state_d   = SEQ_IDLE;
            end
            SEQ_POP_LO: begin
                req.re   = 1'b1;
                req.addr = sp + sp_t'(1);
                step     = STEP_INC;
                state_d  = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SEQ_IDLE;
            hold_q       <= '0;
            pop_data     <= '0;
            pop_valid    <= 1'b0;
            ret_addr_out <= '0;
            ret_valid    <= 1'b0;
        end else begin
            state_q   <= state_d;
            pop_valid <= 1'b0;
            ret_valid <= 1'b0;
            if (accept && op_kind == OP_PUSH_RA)
                hold_q <= ret_addr_in[SP_W-1:BYTE_W];
            if (accept && op_kind == OP_POP_RA)
                hold_q <= mem_rdata;
            if (accept && op_kind == OP_POP_B) begin
                pop_data  <= mem_rdata;
                pop_valid <= 1'b1;
            end
            if (state_q == SEQ_POP_LO) begin
                ret_addr_out <= {hold_q, mem_rdata};
                ret_valid    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/stkptr_ptr.sv
module stkptr_ptr
    import stkptr_pkg::*;
#(
    parameter logic [15:0] RAM_END  = 16'h08FF,
    parameter logic [15:0] FLOOR    = 16'h0100,
    parameter bit          HAS_HIGH = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  sp_step_e step,
    input  logic     reg_we_lo,
    input  logic     reg_we_hi,
    input  byte_t    reg_wdata,
    input  logic     push_we,
    input  sp_t      push_addr,
    output sp_t      sp,
    output logic     stack_err
);

    sp_t  sp_q;
    logic reg_apply;

    assign reg_apply = (step == STEP_HOLD) && (reg_we_lo || reg_we_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= RAM_END;
        end else if (step != STEP_HOLD) begin
            sp_q <= apply_step(sp_q, step);
        end else begin
            if (reg_we_lo)
                sp_q[BYTE_W-1:0] <= reg_wdata;
            if (reg_we_hi && HAS_HIGH)
                sp_q[SP_W-1:BYTE_W] <= reg_wdata;
        end
    end

    generate
        if (HAS_HIGH) begin : g_full
            assign sp = sp_q;
        end else begin : g_low_only
            assign sp = {RAM_END[SP_W-1:BYTE_W], sp_q[BYTE_W-1:0]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            stack_err <= 1'b0;
        else if (reg_apply)
            stack_err <= 1'b0;
        else if (push_we && push_addr < FLOOR)
            stack_err <= 1'b1;
    end

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter logic [15:0] RAM_END  = 16'h08FF,
    parameter logic [15:0] FLOOR    = 16'h0100,
    parameter bit          HAS_HIGH = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [1:0]  op_kind,
    input  logic [7:0]  push_data,
    input  logic [15:0] ret_addr_in,
    input  logic        reg_we_lo,
    input  logic        reg_we_hi,
    input  logic [7:0]  reg_wdata,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    output logic        busy,
    output logic [7:0]  pop_data,
    output logic        pop_valid,
    output logic [15:0] ret_addr_out,
    output logic        ret_valid,
    output logic [7:0]  sp_lo,
    output logic [7:0]  sp_hi,
    output logic        stack_err
);

    mem_req_t req;
    sp_step_e step;
    sp_t      sp;

    stkptr_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .op_valid     (op_valid),
        .op_kind      (stk_op_e'(op_kind)),
        .push_data    (push_data),
        .ret_addr_in  (ret_addr_in),
        .sp           (sp),
        .mem_rdata    (mem_rdata),
        .req          (req),
        .step         (step),
        .busy         (busy),
        .pop_data     (pop_data),
        .pop_valid    (pop_valid),
        .ret_addr_out (ret_addr_out),
        .ret_valid    (ret_valid)
    );

    stkptr_ptr #(
        .RAM_END  (RAM_END),
        .FLOOR    (FLOOR),
        .HAS_HIGH (HAS_HIGH)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .reg_we_lo (reg_we_lo),
        .reg_we_hi (reg_we_hi),
        .reg_wdata (reg_wdata),
        .push_we   (req.we),
        .push_addr (req.addr),
        .sp        (sp),
        .stack_err (stack_err)
    );

    assign mem_addr  = req.addr;
    assign mem_we    = req.we;
    assign mem_re    = req.re;
    assign mem_wdata = req.wdata;
    assign sp_lo     = sp[BYTE_W-1:0];
    assign sp_hi     = sp[SP_W-1:BYTE_W];

endmodule

// File: rtl/stkptr_chk.sv
module stkptr_chk #(
    parameter logic [15:0] RAM_END = 16'h08FF,
    parameter logic [15:0] FLOOR   = 16'h0100
) (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [1:0]  op_kind,
    input logic        reg_we_lo,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        busy,
    input logic        pop_valid,
    input logic        ret_valid,
    input logic [7:0]  sp_lo,
    input logic [7:0]  sp_hi,
    input logic        stack_err
);

    logic [15:0] sp_v;
    assign sp_v = {sp_hi, sp_lo};

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sp_v == RAM_END && !stack_err && !busy && !pop_valid && !ret_valid));

    a_r2_push_dec: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_kind == 2'd0) |=> (sp_v == $past(sp_v) - 16'd1));

    a_r3_pop_inc: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_kind == 2'd1) |=> (pop_valid && sp_v == $past(sp_v) + 16'd1));

    a_r4_call_second_cycle: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_kind == 2'd2) |=> (busy && mem_we));

    a_r5_ret_result: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && op_kind == 2'd3) |=> busy ##1 (ret_valid && sp_v == $past(sp_v, 2) + 16'd2));

    a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    a_r8_reg_blocked: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we_lo && mem_we) |=> (sp_v == $past(sp_v) - 16'd1));

    a_r9_err_sets: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_addr < FLOOR) |=> stack_err);

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

endmodule

bind stkptr_unit stkptr_chk #(
    .RAM_END (RAM_END),
    .FLOOR   (FLOOR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .reg_we_lo (reg_we_lo),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .busy      (busy),
    .pop_valid (pop_valid),
    .ret_valid (ret_valid),
    .sp_lo     (sp_lo),
    .sp_hi     (sp_hi),
    .stack_err (stack_err)
);

// File: tb/stkptr_unit_test.sv
module stkptr_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [7:0]  push_data;
    logic [15:0] ret_addr_in;
    logic        reg_we_lo, reg_we_hi;
    logic [7:0]  reg_wdata;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic        busy;
    logic [7:0]  pop_data;
    logic        pop_valid;
    logic [15:0] ret_addr_out;
    logic        ret_valid;
    logic [7:0]  sp_lo, sp_hi;
    logic        stack_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [7:0] mem [0:4095];

    always #5 clk = ~clk;

    stkptr_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .push_data(push_data), .ret_addr_in(ret_addr_in),
        .reg_we_lo(reg_we_lo), .reg_we_hi(reg_we_hi), .reg_wdata(reg_wdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .busy(busy),
        .pop_data(pop_data), .pop_valid(pop_valid),
        .ret_addr_out(ret_addr_out), .ret_valid(ret_valid),
        .sp_lo(sp_lo), .sp_hi(sp_hi), .stack_err(stack_err)
    );

    assign mem_rdata = mem[mem_addr[11:0]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] spv();
        return {sp_hi, sp_lo};
    endfunction

    task automatic t_reset();
        chk("R1 pointer at reset", spv(), 16'h08FF);
        chk("R1 err at reset", stack_err, 1'b0);
        chk("R1 busy at reset", busy, 1'b0);
        chk("R1 valids at reset", {pop_valid, ret_valid}, 2'b00);
    endtask

    task automatic t_push_byte();
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd0; push_data = 8'hA5;
        #1;
        chk("R2 push write strobe", mem_we, 1'b1);
        chk("R2 push address", mem_addr, 16'h08FF);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2 pointer after push", spv(), 16'h08FE);
        chk("R2 memory byte", mem[12'h8FF], 8'hA5);
    endtask

    task automatic t_pop_byte();
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd1;
        #1;
        chk("R3 pop read address", mem_addr, 16'h08FF);
        chk("R10 strobes exclusive", {mem_re, mem_we}, 2'b10);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R3 pop valid", pop_valid, 1'b1);
        chk("R3 pop data", pop_data, 8'hA5);
        chk("R3 pointer after pop", spv(), 16'h08FF);
        @(negedge clk);
        chk("R3 pop valid single", pop_valid, 1'b0);
    endtask

    task automatic t_call_push();
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd2; ret_addr_in = 16'h1234;
        #1;
        chk("R4 first address", mem_addr, 16'h08FF);
        chk("R4 low byte first", mem_wdata, 8'h34);
        @(negedge clk);
        chk("R4 busy second cycle", busy, 1'b1);
        op_kind = 2'd0; push_data = 8'h77;
        reg_we_lo = 1'b1; reg_wdata = 8'h55;
        #1;
        chk("R4 second address", mem_addr, 16'h08FE);
        chk("R4 high byte second", mem_wdata, 8'h12);
        @(negedge clk);
        op_valid = 1'b0; reg_we_lo = 1'b0;
        chk("R4 busy cleared", busy, 1'b0);
        chk("R4 R8 pointer after call", spv(), 16'h08FD);
        chk("R4 stored low", mem[12'h8FF], 8'h34);
        chk("R4 stored high", mem[12'h8FE], 8'h12);
        chk("R6 request during busy ignored", mem[12'h8FD], 8'h00);
    endtask

    task automatic t_ret_pop();
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd3;
        #1;
        chk("R5 high byte read first", mem_addr, 16'h08FE);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R5 busy second cycle", busy, 1'b1);
        #1;
        chk("R5 low byte read second", mem_addr, 16'h08FF);
        @(negedge clk);
        chk("R5 ret valid", ret_valid, 1'b1);
        chk("R5 ret address", ret_addr_out, 16'h1234);
        chk("R5 pointer after return", spv(), 16'h08FF);
    endtask

    task automatic t_reg_write();
        @(negedge clk);
        reg_we_hi = 1'b1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we_hi = 1'b0;
        chk("R7 high half write", spv(), 16'h01FF);
        reg_we_lo = 1'b1; reg_wdata = 8'h20;
        @(negedge clk);
        reg_we_lo = 1'b0;
        chk("R7 low half write", spv(), 16'h0120);
        reg_we_lo = 1'b1; reg_we_hi = 1'b1; reg_wdata = 8'h02;
        @(negedge clk);
        reg_we_lo = 1'b0; reg_we_hi = 1'b0;
        chk("R7 both halves write", spv(), 16'h0202);
    endtask

    task automatic t_reg_blocked();
        @(negedge clk);
        op_valid = 1'b1; op_kind = 2'd0; push_data = 8'h5A;
        reg_we_hi = 1'b1; reg_wdata = 8'h07;
        @(negedge clk);
        op_valid = 1'b0; reg_we_hi = 1'b0;
        chk("R8 write with accepted push ignored", spv(), 16'h0201);
    endtask

    task automatic t_floor();
        @(negedge clk);
        reg_we_lo = 1'b1; reg_we_hi = 1'b1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we_lo = 1'b0; reg_we_hi = 1'b0;
        op_valid = 1'b1; op_kind = 2'd0; push_data = 8'h11;
        @(negedge clk);
        push_data = 8'h22;
        chk("R9 no err at 0x0101", stack_err, 1'b0);
        @(negedge clk);
        push_data = 8'h33;
        chk("R9 no err at 0x0100", stack_err, 1'b0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 err below floor", stack_err, 1'b1);
        chk("R9 write still done", mem[12'h0FF], 8'h33);
        chk("R9 pointer", spv(), 16'h00FE);
        @(negedge clk);
        chk("R9 err sticky", stack_err, 1'b1);
        reg_we_hi = 1'b1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_we_hi = 1'b0;
        chk("R9 err cleared by write", stack_err, 1'b0);
        reg_we_lo = 1'b1; reg_wdata = 8'h00;
        @(negedge clk);
        reg_we_lo = 1'b0;
        chk("R7 pointer at floor", spv(), 16'h0100);
        op_valid = 1'b1; op_kind = 2'd2; ret_addr_in = 16'hBEEF;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 first call byte at floor ok", stack_err, 1'b0);
        @(negedge clk);
        chk("R9 second call byte below floor", stack_err, 1'b1);
        chk("R4 low byte at floor", mem[12'h100], 8'hEF);
        chk("R4 high byte below floor", mem[12'h0FF], 8'hBE);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        rst = 1'b1; op_valid = 1'b0; op_kind = 2'd0; push_data = '0;
        ret_addr_in = '0; reg_we_lo = 1'b0; reg_we_hi = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_push_byte();
        t_pop_byte();
        t_call_push();
        t_ret_pop();
        t_reg_write();
        t_reg_blocked();
        t_floor();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule